// File: doc/BRIEF.md
# High-Speed Clock Pin Mode and Oscillator Gain Control Register

This block is an 8-bit control register that software writes to configure the two high-speed oscillator pins and the oscillator drive gain. Two mode bits choose whether the pins act as general I/O, drive a crystal or ceramic resonator, or take an external clock. The resonator is on both pins. The external clock enters on the second pin. A gain bit tells the oscillator whether the clock runs above 10 MHz. Software can write the whole byte, or it can set or clear one bit.

Each writable bit has its own lock. The mode bits change only while the main oscillator reports that it is stopped. The gain bit can change once after reset. After that first change, any write that tries to change it again has no effect. When the gain bit rises, the block holds the CPU clock off for a fixed number of reference clock cycles. The block also acts on a STOP-mode release. If the CPU runs from a non-crystal source with high gain, it applies the same hold. If the CPU runs from the crystal, it requests an oscillation stabilization count instead. A sticky flag records that a write was refused by a lock.

Top module: `osc_mode_reg`

## Requirements
- R1: After reset the readback is 0x00, all pin-mode outputs and the gain output are 0, the CPU clock enable is 1, and the stabilization request and the reject flag are 0.
- R2: Bits 5 to 1 always read as 0, whatever value is written to them.
- R3: The mode bits {bit 7, bit 6} decode as follows. 00 and 10 leave both pins as I/O, so all three pin outputs are 0. 01 sets pin_a_osc and pin_b_osc to 1. 11 sets only pin_b_extin.
- R4: A write that would change bit 7 or bit 6 takes effect only while osc_stopped is 1. Otherwise those bits keep their value.
- R5: Bit 0 (gain) changes at most once between resets. A later write that differs from its value leaves it unchanged.
- R6: When the gain bit changes from 0 to 1, cpu_clk_en is 0 for exactly HOLD_CYCLES cycles, starting with the cycle after the write edge.
- R7: A stop_release pulse while gain is 1 and cpu_src is 00 (internal oscillator), 01 (external clock) or 11 forces the same HOLD_CYCLES hold. With gain at 0 it leaves cpu_clk_en at 1.
- R8: A stop_release pulse with cpu_src 10 (crystal) raises stab_start for one cycle after the edge and does not hold the CPU clock.
- R9: A single-bit write (bit_wr_en with bit_sel, bit_val) acts only on the selected bit. A byte write applies each bit under its own lock. Byte writes take priority when both write strobes are high.
- R10: lock_reject becomes 1 after any write that a lock refused. It returns to 0 after the next write that no lock refused. It holds its value when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Position of the bit to write |
| bit_val | input | 1 | Value for the single-bit write |
| osc_stopped | input | 1 | Main oscillator stopped flag |
| stop_release | input | 1 | STOP-mode release pulse |
| cpu_src | input | 2 | CPU clock source: 00 internal, 01 external, 10 crystal, 11 reserved |
| rd_data | output | 8 | Register readback |
| pin_a_osc | output | 1 | First pin used by the resonator |
| pin_b_osc | output | 1 | Second pin used by the resonator |
| pin_b_extin | output | 1 | Second pin used as external clock input |
| gain_hi | output | 1 | High-frequency gain select |
| cpu_clk_en | output | 1 | CPU clock enable |
| stab_start | output | 1 | Oscillation stabilization count request |
| lock_reject | output | 1 | Sticky write-refused flag |

## Verification
Register contents, the gain output and the reject flag update at the write edge. The pin decode follows the stored bits with no further register stage, so all of these results are due one edge after the write. The CPU clock enable drops in that same cycle and then stays low for exactly HOLD_CYCLES cycles. stab_start is registered and is high only in the cycle after the edge that samples stop_release. The bench drives each stimulus on a falling edge and waits for the next rising edge. It samples on the falling edge that follows. To measure a hold, it counts the consecutive falling-edge samples in which the enable is low.

// File: rtl/osc_mode_pkg.sv
`timescale 1ns/1ps
package osc_mode_pkg;
   localparam int REG_W    = 8;
   localparam int GAIN_BIT = 0;
   localparam int OSC_BIT  = 6;
   localparam int EXT_BIT  = 7;

   // mode pair {ext, osc}
   typedef enum logic [1:0] {
      PM_IO_A  = 2'b00,
      PM_XTAL  = 2'b01,
      PM_IO_B  = 2'b10,
      PM_EXTIN = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      CS_INT_OSC = 2'b00,
      CS_EXT_CLK = 2'b01,
      CS_XTAL    = 2'b10,
      CS_RSVD    = 2'b11
   } cpu_src_e;
endpackage

// File: rtl/osc_mode_regfile.sv
`timescale 1ns/1ps
module osc_mode_regfile
   import osc_mode_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         bit_wr_en,
   input  logic [2:0]   bit_sel,
   input  logic         bit_val,
   input  logic         osc_stopped,
   output logic [W-1:0] reg_q,
   output logic         gain_rise,
   output logic         reject_q
);
   logic [W-1:0] nxt;
   logic [W-1:0] rej;
   logic         gain_used;
   logic         gain_take;
   logic         any_wr;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == GAIN_BIT) begin : g_gain
         logic sel_w, val_w, try_w;
         assign sel_w  = wr_en | (bit_wr_en & (bit_sel == 3'(i)));
         assign val_w  = wr_en ? wr_data[i] : bit_val;
         assign try_w  = sel_w & (val_w != reg_q[i]);
         assign gain_take = try_w & ~gain_used;
         assign rej[i] = try_w & gain_used;
         assign nxt[i] = gain_take ? val_w : reg_q[i];
      end else if (i == EXT_BIT || i == OSC_BIT) begin : g_mode
         logic sel_w, val_w, try_w;
         assign sel_w  = wr_en | (bit_wr_en & (bit_sel == 3'(i)));
         assign val_w  = wr_en ? wr_data[i] : bit_val;
         assign try_w  = sel_w & (val_w != reg_q[i]);
         assign rej[i] = try_w & ~osc_stopped;
         assign nxt[i] = (try_w & osc_stopped) ? val_w : reg_q[i];
      end else begin : g_pad
         assign rej[i] = 1'b0;
         assign nxt[i] = 1'b0;
      end
   end

   logic unused_pad;
   assign unused_pad = ^wr_data;

   assign any_wr    = wr_en | bit_wr_en;
   assign gain_rise = gain_take & nxt[GAIN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q     <= '0;
         gain_used <= 1'b0;
         reject_q  <= 1'b0;
      end else begin
         reg_q <= nxt;
         if (gain_take) gain_used <= 1'b1;
         if (any_wr)    reject_q  <= |rej;
      end
   end
endmodule

// File: rtl/osc_mode_pindec.sv
`timescale 1ns/1ps
module osc_mode_pindec
   import osc_mode_pkg::*;
(
   input  logic [1:0] mode,
   output logic       pin_a_osc,
   output logic       pin_b_osc,
   output logic       pin_b_extin
);
   pin_mode_e pm;
   assign pm = pin_mode_e'(mode);

   always_comb begin
      pin_a_osc   = 1'b0;
      pin_b_osc   = 1'b0;
      pin_b_extin = 1'b0;
      unique case (pm)
         PM_XTAL:  begin pin_a_osc = 1'b1; pin_b_osc = 1'b1; end
         PM_EXTIN: pin_b_extin = 1'b1;
         default:  ;
      endcase
   end
endmodule

// File: rtl/osc_mode_hold.sv
`timescale 1ns/1ps
module osc_mode_hold #(
   parameter int HOLD_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic clk_en
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (trig)           cnt <= CNT_W'(HOLD_CYCLES);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign clk_en = (cnt == '0);
endmodule

// File: rtl/osc_mode_reg.sv
`timescale 1ns/1ps
module osc_mode_reg
   import osc_mode_pkg::*;
#(
   parameter int HOLD_CYCLES = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       bit_wr_en,
   input  logic [2:0] bit_sel,
   input  logic       bit_val,
   input  logic       osc_stopped,
   input  logic       stop_release,
   input  logic [1:0] cpu_src,
   output logic [7:0] rd_data,
   output logic       pin_a_osc,
   output logic       pin_b_osc,
   output logic       pin_b_extin,
   output logic       gain_hi,
   output logic       cpu_clk_en,
   output logic       stab_start,
   output logic       lock_reject
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end
   if (REG_W != 8) begin : g_bad_width
      $error("register width must be 8");
   end

   logic [REG_W-1:0] reg_q;
   logic             gain_rise;
   logic             from_xtal;
   logic             hold_trig;
   logic             stab_q;

   osc_mode_regfile #(.W(REG_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .bit_wr_en   (bit_wr_en),
      .bit_sel     (bit_sel),
      .bit_val     (bit_val),
      .osc_stopped (osc_stopped),
      .reg_q       (reg_q),
      .gain_rise   (gain_rise),
      .reject_q    (lock_reject)
   );

   osc_mode_pindec u_dec (
      .mode        ({reg_q[EXT_BIT], reg_q[OSC_BIT]}),
      .pin_a_osc   (pin_a_osc),
      .pin_b_osc   (pin_b_osc),
      .pin_b_extin (pin_b_extin)
   );

   assign from_xtal = (cpu_src_e'(cpu_src) == CS_XTAL);
   assign hold_trig = gain_rise | (stop_release & reg_q[GAIN_BIT] & ~from_xtal);

   osc_mode_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (hold_trig),
      .clk_en (cpu_clk_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) stab_q <= 1'b0;
      else        stab_q <= stop_release & from_xtal;
   end

   assign stab_start = stab_q;
   assign rd_data    = reg_q;
   assign gain_hi    = reg_q[GAIN_BIT];
endmodule

// File: rtl/osc_mode_reg_chk.sv
`timescale 1ns/1ps
module osc_mode_reg_chk #(
   parameter int HOLD_CYCLES = 40
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       bit_wr_en,
   input logic       osc_stopped,
   input logic       stop_release,
   input logic [1:0] cpu_src,
   input logic [7:0] rd_data,
   input logic       pin_a_osc,
   input logic       pin_b_osc,
   input logic       pin_b_extin,
   input logic       gain_hi,
   input logic       cpu_clk_en,
   input logic       stab_start,
   input logic       lock_reject
);
   logic gain_prev, gain_moved;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_prev  <= 1'b0;
         gain_moved <= 1'b0;
      end else begin
         gain_prev <= gain_hi;
         if (gain_hi != gain_prev) gain_moved <= 1'b1;
      end
   end

   p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5:1] == 5'b0);

   p_ext_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7:6] == 2'b11) |-> (pin_b_extin && !pin_a_osc && !pin_b_osc));

   p_mode_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_stopped |=> $stable(rd_data[7:6]));

   p_gain_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gain_moved |-> (gain_hi == gain_prev));

   p_hold_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gain_hi) |-> !cpu_clk_en);

   p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_release && gain_hi && cpu_src != 2'b10) |=> !cpu_clk_en);

   p_stab_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stab_start |-> ($past(stop_release) && $past(cpu_src) == 2'b10));

   p_xtal_nohold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_release && cpu_src == 2'b10 && cpu_clk_en && !wr_en && !bit_wr_en)
      |=> cpu_clk_en);

   p_reject_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !bit_wr_en) |=> $stable(lock_reject));
endmodule

bind osc_mode_reg osc_mode_reg_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .bit_wr_en    (bit_wr_en),
   .osc_stopped  (osc_stopped),
   .stop_release (stop_release),
   .cpu_src      (cpu_src),
   .rd_data      (rd_data),
   .pin_a_osc    (pin_a_osc),
   .pin_b_osc    (pin_b_osc),
   .pin_b_extin  (pin_b_extin),
   .gain_hi      (gain_hi),
   .cpu_clk_en   (cpu_clk_en),
   .stab_start   (stab_start),
   .lock_reject  (lock_reject)
);

// File: tb/test_osc_mode_reg.sv
`timescale 1ns/1ps
module test_osc_mode_reg;
   localparam int HOLD = 40;
   // {osc_stopped, wr_data, exp_rd, exp_reject, exp {pin_a_osc,pin_b_osc,pin_b_extin}}
   localparam int NV = 7;
   localparam logic [20:0] VEC [NV] = '{
      {1'b0, 8'hC0, 8'h00, 1'b1, 3'b000},
      {1'b1, 8'h40, 8'h40, 1'b0, 3'b110},
      {1'b1, 8'hFE, 8'hC0, 1'b0, 3'b001},
      {1'b0, 8'h00, 8'hC0, 1'b1, 3'b001},
      {1'b1, 8'h80, 8'h80, 1'b0, 3'b000},
      {1'b0, 8'h80, 8'h80, 1'b0, 3'b000},
      {1'b1, 8'h00, 8'h00, 1'b0, 3'b000}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       bit_wr_en = 1'b0;
   logic [2:0] bit_sel = '0;
   logic       bit_val = 1'b0;
   logic       osc_stopped = 1'b0;
   logic       stop_release = 1'b0;
   logic [1:0] cpu_src = 2'b00;
   logic [7:0] rd_data;
   logic       pin_a_osc, pin_b_osc, pin_b_extin;
   logic       gain_hi, cpu_clk_en, stab_start, lock_reject;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   osc_mode_reg #(.HOLD_CYCLES(HOLD)) i_osc_mode_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val),
      .osc_stopped(osc_stopped), .stop_release(stop_release), .cpu_src(cpu_src),
      .rd_data(rd_data), .pin_a_osc(pin_a_osc), .pin_b_osc(pin_b_osc),
      .pin_b_extin(pin_b_extin), .gain_hi(gain_hi), .cpu_clk_en(cpu_clk_en),
      .stab_start(stab_start), .lock_reject(lock_reject)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic byte_wr(input logic stopped, input logic [7:0] d);
      @(negedge clk); osc_stopped = stopped; wr_en = 1'b1; wr_data = d;
      @(posedge clk); @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bit_wr(input logic stopped, input logic [2:0] s, input logic v);
      @(negedge clk); osc_stopped = stopped; bit_wr_en = 1'b1; bit_sel = s; bit_val = v;
      @(posedge clk); @(negedge clk); bit_wr_en = 1'b0;
   endtask

   task automatic release_stop(input logic [1:0] src);
      @(negedge clk); cpu_src = src; stop_release = 1'b1;
      @(posedge clk); @(negedge clk); stop_release = 1'b0;
   endtask

   task automatic hold_len(output int n);
      n = 0;
      while (!cpu_clk_en && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int len;
      do_reset();
      // R1 reset state
      check("R1 rd", rd_data, 8'h00);
      check("R1 pins", {pin_a_osc, pin_b_osc, pin_b_extin}, 3'b000);
      check("R1 gain", gain_hi, 1'b0);
      check("R1 clk_en", cpu_clk_en, 1'b1);
      check("R1 stab", stab_start, 1'b0);
      check("R1 reject", lock_reject, 1'b0);

      // vector walk: R2 R3 R4 R9 R10
      for (int k = 0; k < NV; k++) begin
         byte_wr(VEC[k][20], VEC[k][19:12]);
         check("R4 R9 rd", rd_data, VEC[k][11:4]);
         check("R10 reject", lock_reject, VEC[k][3]);
         check("R3 pins", {pin_a_osc, pin_b_osc, pin_b_extin}, VEC[k][2:0]);
         check("R2 pad", rd_data[5:1], 5'b0);
      end

      // R9 single-bit writes
      bit_wr(1'b1, 3'd6, 1'b1);
      check("R9 bit6", rd_data, 8'h40);
      check("R3 xtal", {pin_a_osc, pin_b_osc, pin_b_extin}, 3'b110);
      bit_wr(1'b1, 3'd3, 1'b1);
      check("R2 bit3", rd_data, 8'h40);
      bit_wr(1'b0, 3'd7, 1'b1);
      check("R4 bit7 locked", rd_data, 8'h40);
      check("R10 set", lock_reject, 1'b1);
      // no write: flag holds
      @(negedge clk);
      check("R10 hold", lock_reject, 1'b1);

      // R7 gain 0: no hold on release
      release_stop(2'b00);
      check("R7 gain0 en", cpu_clk_en, 1'b1);

      // R6 gain rise hold
      bit_wr(1'b0, 3'd0, 1'b1);
      check("R6 gain", gain_hi, 1'b1);
      check("R10 clear", lock_reject, 1'b0);
      check("R9 rd", rd_data, 8'h41);
      hold_len(len);
      check("R6 hold len", len, HOLD);

      // R5 gain locked
      byte_wr(1'b0, 8'h40);
      check("R5 byte locked", rd_data, 8'h41);
      check("R10 gain reject", lock_reject, 1'b1);
      check("R6 no new hold", cpu_clk_en, 1'b1);
      bit_wr(1'b1, 3'd0, 1'b0);
      check("R5 bit locked", gain_hi, 1'b1);
      byte_wr(1'b0, 8'h41);
      check("R10 accepted", lock_reject, 1'b0);

      // R7 release holds from internal and external sources
      release_stop(2'b00);
      hold_len(len);
      check("R7 int hold", len, HOLD);
      release_stop(2'b01);
      check("R8 no stab ext", stab_start, 1'b0);
      hold_len(len);
      check("R7 ext hold", len, HOLD);

      // R8 crystal release
      release_stop(2'b10);
      check("R8 stab pulse", stab_start, 1'b1);
      check("R8 no hold", cpu_clk_en, 1'b1);
      @(negedge clk);
      check("R8 stab single", stab_start, 1'b0);

      // R1/R5 reset re-arms the gain bit
      do_reset();
      check("R1 rd again", rd_data, 8'h00);
      check("R1 en again", cpu_clk_en, 1'b1);
      byte_wr(1'b0, 8'h01);
      check("R5 rearmed", gain_hi, 1'b1);
      hold_len(len);
      check("R6 hold again", len, HOLD);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule